// File: doc/BRIEF.md
# DMA Write Burst Buffer and Bus Request Controller

This block sits between a local communications processor that writes DMA data toward host memory and the host-side bus master. A status cycle carrying the write-start code opens a transaction. The block first asks for a read of the processor's transfer-length register. Only after that read completes does it hand the local bus to the processor. Incoming 32-bit words are held in a 64-byte store, and a byte-granular fill count is kept.

The block decides when to raise a host bus request and which command the burst carries. A memory-write-and-invalidate (command code 4'hF) is used when at least one whole cache line is buffered and the next host address sits on a line boundary. A plain memory write (command code 4'h7) is used in every other case. A request is raised on any of four conditions: a full aligned line is buffered, 60 bytes are buffered, the processor has released its bus with data left over, or the line size is zero and one word is buffered. Once the host grants the bus, the block drives one word per cycle with an address that climbs by 4. If the bus is lost, the buffered data and the address are kept and the request is raised again under the same rules.

Top module: `dmaw_burst_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, hb_req, len_rd_req, lcl_grant, wr_ready and bd_valid are low.
- R2: A status cycle with stat_code equal to 4'hA, seen while no transaction is open, raises len_rd_req on the next cycle. lcl_grant stays low until len_rd_done is seen. On the cycle after that, lcl_grant is high and len_rd_req is low.
- R3: A status cycle carrying any code other than 4'hA, or any status cycle while a transaction is open, does not raise len_rd_req, so the length register is read once per transaction.
- R4: With cache_line_words a nonzero power of two, the block raises hb_req with burst_cmd 4'hF once at least cache_line_words words are buffered and the next host word address is a multiple of cache_line_words. burst_cmd stays constant for as long as hb_req stays high.
- R5: With cache_line_words zero, hb_req is raised with burst_cmd 4'h7 as soon as one word is buffered.
- R6: When 60 bytes are buffered, hb_req is raised even when the line condition of R4 does not hold, and burst_cmd is then 4'h7.
- R7: lcl_release drops lcl_grant on the next cycle. Any data still buffered is then requested: with 4'hF if R4's line and alignment test holds, otherwise with 4'h7.
- R8: After hb_gnt, one buffered word per cycle appears on bd_data with bd_valid high, in arrival order. bd_addr starts at the address captured with the start status cycle and rises by 4 per word. A 4'hF burst moves whole lines only and ends when fewer than one line remains.
- R9: hb_lost while hb_req is high yields no word on the next cycle and drops hb_req. No buffered word or address step is lost, and the request is raised again by the same rules.
- R10: The store holds 16 words. wr_ready is low when it is full, and a word offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_valid | input | 1 | Status cycle present on the local bus |
| stat_code | input | 4 | Status cycle code |
| dma_addr | input | 32 | Host start address, captured with the start code |
| len_rd_req | output | 1 | Request to read the transfer-length register |
| len_rd_done | input | 1 | Length register read has completed |
| lcl_grant | output | 1 | Local bus granted to the processor |
| lcl_release | input | 1 | Processor gives the local bus back at the end of the write |
| wr_valid | input | 1 | DMA write word offered |
| wr_data | input | 32 | DMA write word |
| wr_ready | output | 1 | Word is accepted this cycle |
| cache_line_words | input | 8 | Cache line size in 32-bit words, 0 or a power of two |
| hb_req | output | 1 | Host bus request |
| hb_gnt | input | 1 | Host bus grant |
| hb_lost | input | 1 | Host bus taken away |
| burst_cmd | output | 4 | Burst command, 4'hF invalidate-write or 4'h7 plain write |
| bd_valid | output | 1 | Burst word valid |
| bd_addr | output | 32 | Host address of the burst word |
| bd_data | output | 32 | Burst word |

## Verification
The bench uses the default parameters: 32-bit words, a 64-byte store and a 60-byte early threshold. With these values both a completely full store and the threshold firing one word short of a 16-word line can be reached within a few cycles. The bench sets cache_line_words to 0, 2, 4, 8 and 16, and uses start addresses both on and off line boundaries. This covers every trigger condition, both command choices, split multi-line bursts and a trailing plain-write remainder. The host grant is held back while data is loaded, so the triggering condition can be read before release. A bus loss is forced after two words to show that the request resumes where it stopped.

// File: rtl/dmaw_pkg.sv
`timescale 1ns/1ps
package dmaw_pkg;
  typedef enum logic [1:0] {C_IDLE, C_LEN, C_XFER, C_DRAIN} ctl_st_t;
  typedef enum logic [1:0] {B_IDLE, B_REQ, B_RUN} bst_st_t;
  localparam logic [3:0] CMD_MW  = 4'h7;
  localparam logic [3:0] CMD_MWI = 4'hF;
endpackage

// File: rtl/dmaw_fifo.sv
`timescale 1ns/1ps
module dmaw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int BPW   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH * BPW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fill_bytes
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // storage: write port and registered read port, block-RAM style
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
    if (pop)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill_bytes <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill_bytes <= fill_bytes + CW'(BPW);
        2'b01:   fill_bytes <= fill_bytes - CW'(BPW);
        default: fill_bytes <= fill_bytes;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_ctl.sv
`timescale 1ns/1ps
module dmaw_ctl
  import dmaw_pkg::*;
#(
  parameter int STW        = 4,
  parameter int START_CODE = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stat_valid,
  input  logic [STW-1:0] stat_code,
  input  logic           len_rd_done,
  input  logic           lcl_release,
  input  logic           fifo_empty,
  input  logic           burst_idle,
  output logic           start,
  output logic           active,
  output logic           draining,
  output logic           len_rd_req,
  output logic           lcl_grant
);
  ctl_st_t st;

  assign start    = (st == C_IDLE) && stat_valid && (stat_code == STW'(START_CODE));
  assign active   = (st == C_XFER) || (st == C_DRAIN);
  assign draining = (st == C_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= C_IDLE;
      len_rd_req <= 1'b0;
      lcl_grant  <= 1'b0;
    end else begin
      case (st)
        C_IDLE: if (start) begin
          st         <= C_LEN;
          len_rd_req <= 1'b1;
        end
        C_LEN: if (len_rd_done) begin
          st         <= C_XFER;
          len_rd_req <= 1'b0;
          lcl_grant  <= 1'b1;
        end
        C_XFER: if (lcl_release) begin
          st        <= C_DRAIN;
          lcl_grant <= 1'b0;
        end
        C_DRAIN: if (fifo_empty && burst_idle) st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_burst.sv
`timescale 1ns/1ps
module dmaw_burst
  import dmaw_pkg::*;
#(
  parameter int ADRW       = 32,
  parameter int CLSW       = 8,
  parameter int DEPTH      = 16,
  parameter int BPW        = 4,
  parameter int FILL_BYTES = 60,
  localparam int CW        = $clog2(DEPTH * BPW + 1),
  localparam int BSH       = $clog2(BPW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ADRW-1:0] start_addr,
  input  logic [CLSW-1:0] cls,
  input  logic            active,
  input  logic            draining,
  input  logic [CW-1:0]   fill_bytes,
  input  logic            push,
  input  logic            hb_gnt,
  input  logic            hb_lost,
  output logic            pop,
  output logic            idle,
  output logic            hb_req,
  output logic [3:0]      burst_cmd,
  output logic            bd_valid,
  output logic [ADRW-1:0] bd_addr
);
  bst_st_t         st;
  logic [ADRW-1:0] addr;
  logic [CLSW-1:0] line_ctr;
  logic [CW-1:0]   words;
  logic            aligned, line_ok, trig;
  int              nxt_words;

  assign words     = fill_bytes >> BSH;
  assign aligned   = (addr[BSH +: CLSW] & (cls - CLSW'(1))) == '0;
  assign line_ok   = (cls != '0) && (int'(cls) <= DEPTH) &&
                     (int'(words) >= int'(cls)) && aligned;
  assign trig      = active && (line_ok ||
                                ((cls == '0) && (words != '0)) ||
                                (int'(fill_bytes) >= FILL_BYTES) ||
                                (draining && (words != '0)));
  assign pop       = (st == B_RUN) && !hb_lost && (words != '0);
  assign nxt_words = int'(words) - int'(pop) + int'(push);
  assign idle      = (st == B_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      hb_req    <= 1'b0;
      burst_cmd <= CMD_MW;
      bd_valid  <= 1'b0;
      bd_addr   <= '0;
      addr      <= '0;
      line_ctr  <= '0;
    end else begin
      bd_valid <= pop;
      if (start) addr <= start_addr;
      if (pop) begin
        bd_addr <= addr;
        addr    <= addr + ADRW'(BPW);
      end
      case (st)
        B_IDLE: if (trig) begin
          hb_req    <= 1'b1;
          burst_cmd <= line_ok ? CMD_MWI : CMD_MW;
          line_ctr  <= '0;
          st        <= B_REQ;
        end
        B_REQ: if (hb_lost) begin
          hb_req <= 1'b0;
          st     <= B_IDLE;
        end else if (hb_gnt) begin
          st <= B_RUN;
        end
        B_RUN: if (hb_lost || (words == '0)) begin
          hb_req <= 1'b0;
          st     <= B_IDLE;
        end else if (burst_cmd == CMD_MWI) begin
          if (line_ctr == cls - CLSW'(1)) begin
            line_ctr <= '0;
            if (nxt_words < int'(cls)) begin
              hb_req <= 1'b0;
              st     <= B_IDLE;
            end
          end else begin
            line_ctr <= line_ctr + 1'b1;
          end
        end else if (nxt_words == 0) begin
          hb_req <= 1'b0;
          st     <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_burst_ctrl.sv
`timescale 1ns/1ps
module dmaw_burst_ctrl #(
  parameter int DW         = 32,
  parameter int ADRW       = 32,
  parameter int STW        = 4,
  parameter int START_CODE = 10,
  parameter int FIFO_BYTES = 64,
  parameter int FILL_BYTES = 60,
  parameter int CLSW       = 8,
  localparam int BPW       = DW / 8,
  localparam int DEPTH     = FIFO_BYTES / BPW,
  localparam int CW        = $clog2(FIFO_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stat_valid,
  input  logic [STW-1:0]  stat_code,
  input  logic [ADRW-1:0] dma_addr,
  output logic            len_rd_req,
  input  logic            len_rd_done,
  output logic            lcl_grant,
  input  logic            lcl_release,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  input  logic [CLSW-1:0] cache_line_words,
  output logic            hb_req,
  input  logic            hb_gnt,
  input  logic            hb_lost,
  output logic [3:0]      burst_cmd,
  output logic            bd_valid,
  output logic [ADRW-1:0] bd_addr,
  output logic [DW-1:0]   bd_data
);
  logic          start, active, draining, burst_idle, push, pop;
  logic [CW-1:0] fill_bytes;

  assign wr_ready = lcl_grant && (int'(fill_bytes) < FIFO_BYTES);
  assign push     = wr_valid && wr_ready;

  dmaw_ctl #(.STW(STW), .START_CODE(START_CODE)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .stat_valid (stat_valid),
    .stat_code  (stat_code),
    .len_rd_done(len_rd_done),
    .lcl_release(lcl_release),
    .fifo_empty (fill_bytes == '0),
    .burst_idle (burst_idle),
    .start      (start),
    .active     (active),
    .draining   (draining),
    .len_rd_req (len_rd_req),
    .lcl_grant  (lcl_grant)
  );

  dmaw_fifo #(.DW(DW), .DEPTH(DEPTH), .BPW(BPW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (wr_data),
    .pop       (pop),
    .pop_data  (bd_data),
    .fill_bytes(fill_bytes)
  );

  dmaw_burst #(
    .ADRW(ADRW), .CLSW(CLSW), .DEPTH(DEPTH), .BPW(BPW), .FILL_BYTES(FILL_BYTES)
  ) u_burst (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_addr(dma_addr),
    .cls       (cache_line_words),
    .active    (active),
    .draining  (draining),
    .fill_bytes(fill_bytes),
    .push      (push),
    .hb_gnt    (hb_gnt),
    .hb_lost   (hb_lost),
    .pop       (pop),
    .idle      (burst_idle),
    .hb_req    (hb_req),
    .burst_cmd (burst_cmd),
    .bd_valid  (bd_valid),
    .bd_addr   (bd_addr)
  );
endmodule

// File: rtl/dmaw_burst_ctrl_chk.sv
`timescale 1ns/1ps
module dmaw_burst_ctrl_chk #(
  parameter int ADRW       = 32,
  parameter int STW        = 4,
  parameter int START_CODE = 10,
  parameter int BPW        = 4,
  parameter int CW         = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            stat_valid,
  input logic [STW-1:0]  stat_code,
  input logic            len_rd_req,
  input logic            len_rd_done,
  input logic            lcl_grant,
  input logic            lcl_release,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            hb_req,
  input logic            hb_lost,
  input logic [3:0]      burst_cmd,
  input logic            bd_valid,
  input logic [ADRW-1:0] bd_addr,
  input logic [CW-1:0]   fill_bytes
);
  assert_grant_after_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lcl_grant) |-> $past(len_rd_done));

  assert_len_only_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(len_rd_req) |-> ($past(stat_valid) && ($past(stat_code) == STW'(START_CODE))));

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (hb_req && $past(hb_req)) |-> $stable(burst_cmd));

  assert_release_drops_R7: assert property (@(posedge clk) disable iff (rst)
    lcl_release |=> !lcl_grant);

  assert_beat_under_req_R8: assert property (@(posedge clk) disable iff (rst)
    bd_valid |-> $past(hb_req));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
    (bd_valid && $past(bd_valid)) |-> (bd_addr == $past(bd_addr) + ADRW'(BPW)));

  assert_lost_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (hb_lost && hb_req) |=> (!bd_valid && !hb_req));

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (fill_bytes <= $past(fill_bytes)));
endmodule

bind dmaw_burst_ctrl dmaw_burst_ctrl_chk #(
  .ADRW(ADRW), .STW(STW), .START_CODE(START_CODE), .BPW(BPW), .CW(CW)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_valid (stat_valid),
  .stat_code  (stat_code),
  .len_rd_req (len_rd_req),
  .len_rd_done(len_rd_done),
  .lcl_grant  (lcl_grant),
  .lcl_release(lcl_release),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .hb_req     (hb_req),
  .hb_lost    (hb_lost),
  .burst_cmd  (burst_cmd),
  .bd_valid   (bd_valid),
  .bd_addr    (bd_addr),
  .fill_bytes (fill_bytes)
);

// File: tb/test_dmaw_burst_ctrl.sv
`timescale 1ns/1ps
module test_dmaw_burst_ctrl;
  localparam logic [3:0] START = 4'hA;
  localparam logic [3:0] MW    = 4'h7;
  localparam logic [3:0] MWI   = 4'hF;

  // {cls[55:48], addr[47:16], words[15:8], pre-release request[4], first command[3:0]}
  localparam int NV = 9;
  localparam logic [55:0] VEC [NV] = '{
    {8'd4,  32'h0000_1000, 8'd4,  4'd1, 4'hF},
    {8'd4,  32'h0000_1004, 8'd4,  4'd0, 4'h7},
    {8'd4,  32'h0000_1100, 8'd3,  4'd0, 4'h7},
    {8'd0,  32'h0000_2000, 8'd1,  4'd1, 4'h7},
    {8'd8,  32'h0000_3000, 8'd8,  4'd1, 4'hF},
    {8'd8,  32'h0000_3010, 8'd15, 4'd1, 4'h7},
    {8'd8,  32'h0000_3010, 8'd14, 4'd0, 4'h7},
    {8'd16, 32'h0000_4000, 8'd16, 4'd1, 4'h7},
    {8'd2,  32'h0000_5008, 8'd5,  4'd1, 4'hF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stat_valid = 1'b0;
  logic [3:0]  stat_code = '0;
  logic [31:0] dma_addr = '0;
  logic        len_rd_req, len_rd_done = 1'b0;
  logic        lcl_grant, lcl_release = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic [7:0]  cls = '0;
  logic        hb_req, hb_gnt = 1'b0, hb_lost = 1'b0;
  logic [3:0]  burst_cmd;
  logic        bd_valid;
  logic [31:0] bd_addr, bd_data;
  int          nchk = 0;
  int          nerr = 0;

  always #2.5 clk = ~clk;

  dmaw_burst_ctrl i_dmaw_burst_ctrl (
    .clk(clk), .rst(rst), .stat_valid(stat_valid), .stat_code(stat_code),
    .dma_addr(dma_addr), .len_rd_req(len_rd_req), .len_rd_done(len_rd_done),
    .lcl_grant(lcl_grant), .lcl_release(lcl_release), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .cache_line_words(cls),
    .hb_req(hb_req), .hb_gnt(hb_gnt), .hb_lost(hb_lost), .burst_cmd(burst_cmd),
    .bd_valid(bd_valid), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  function automatic logic [31:0] pat(input int vid, input int i);
    return 32'hA500_0000 | 32'(vid << 8) | 32'(i);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_txn(input logic [7:0] c, input logic [31:0] a);
    cls = c; dma_addr = a;
    stat_valid = 1'b1; stat_code = START;
    @(negedge clk);
    stat_valid = 1'b0;
    check("R2 length read raised", 32'(len_rd_req), 32'd1);
    check("R2 grant held before read", 32'(lcl_grant), 32'd0);
    cyc(2);
    check("R2 grant still held", 32'(lcl_grant), 32'd0);
    len_rd_done = 1'b1;
    @(negedge clk);
    len_rd_done = 1'b0;
    check("R2 grant after read", 32'(lcl_grant), 32'd1);
    check("R2 length read dropped", 32'(len_rd_req), 32'd0);
  endtask

  task automatic push_words(input int vid, input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = pat(vid, i);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic release_bus();
    lcl_release = 1'b1;
    @(negedge clk);
    lcl_release = 1'b0;
    check("R7 grant dropped on release", 32'(lcl_grant), 32'd0);
  endtask

  task automatic collect(input int n, input logic [31:0] a, input int vid, input int first);
    int got = 0;
    int to = 0;
    hb_gnt = 1'b1;
    while (got < n && to < 200) begin
      @(negedge clk);
      if (bd_valid) begin
        check("R8 burst address", bd_addr, a + 32'(4 * (first + got)));
        check("R8 burst data order", bd_data, pat(vid, first + got));
        got++;
      end
      to++;
    end
    check("R8 word count", 32'(got), 32'(n));
    cyc(4);
    check("R8 no extra word", 32'(bd_valid), 32'd0);
    hb_gnt = 1'b0;
    check("R8 request ends when empty", 32'(hb_req), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 request in reset", 32'(hb_req), 32'd0);
    check("R1 grant in reset", 32'(lcl_grant), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 length read after reset", 32'(len_rd_req), 32'd0);
    check("R1 ready after reset", 32'(wr_ready), 32'd0);
    check("R1 valid after reset", 32'(bd_valid), 32'd0);

    // R3: a non-start code opens nothing
    stat_valid = 1'b1; stat_code = 4'h3;
    @(negedge clk);
    stat_valid = 1'b0;
    check("R3 other code ignored", 32'(len_rd_req), 32'd0);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  c   = VEC[v][55:48];
      logic [31:0] a   = VEC[v][47:16];
      int          n   = int'(VEC[v][15:8]);
      logic        pre = VEC[v][4];
      logic [3:0]  cmd = VEC[v][3:0];
      open_txn(c, a);
      push_words(v, n);
      cyc(3);
      check("R4 R5 R6 request before release", 32'(hb_req), 32'(pre));
      if (pre) check("R4 R5 R6 command", 32'(burst_cmd), 32'(cmd));
      release_bus();
      if (!pre) begin
        cyc(2);
        check("R7 request after release", 32'(hb_req), 32'd1);
        check("R7 command after release", 32'(burst_cmd), 32'(cmd));
      end
      collect(n, a, v, 0);
      cyc(3);
    end

    // R3 and R9: restart code inside an open transaction, then a bus loss
    open_txn(8'd0, 32'h0000_6000);
    stat_valid = 1'b1; stat_code = START;
    @(negedge clk);
    stat_valid = 1'b0;
    cyc(1);
    check("R3 start inside transaction ignored", 32'(len_rd_req), 32'd0);
    push_words(20, 4);
    release_bus();
    begin
      int got = 0;
      int to = 0;
      hb_gnt = 1'b1;
      while (got < 2 && to < 50) begin
        @(negedge clk);
        if (bd_valid) begin
          check("R9 word before loss", bd_data, pat(20, got));
          got++;
        end
        to++;
      end
      hb_lost = 1'b1; hb_gnt = 1'b0;
      @(negedge clk);
      hb_lost = 1'b0;
      check("R9 no word after loss", 32'(bd_valid), 32'd0);
      check("R9 request dropped", 32'(hb_req), 32'd0);
      cyc(2);
      check("R9 request raised again", 32'(hb_req), 32'd1);
      check("R9 command after loss", 32'(burst_cmd), 32'(MW));
      collect(2, 32'h0000_6000, 20, 2);
    end
    cyc(3);

    // R10: a seventeenth word is refused
    open_txn(8'd0, 32'h0000_7000);
    for (int i = 0; i < 17; i++) begin
      wr_valid = 1'b1; wr_data = pat(21, i);
      if (i == 16) check("R10 ready low when full", 32'(wr_ready), 32'd0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    release_bus();
    collect(16, 32'h0000_7000, 21, 0);
    check("R10 unused MWI code stays out", 32'(burst_cmd == MWI), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule